// File: doc/BRIEF.md
# Authentication Trigger and Status Controller

This block decides when a challenge-and-response authentication of an attached token should begin, and it shows the outcome on two status lines that behave like active-low open-drain pins. It can be triggered in four ways: by the level of a challenge pin sampled once a challenge delay after power-up, by a later edge on that pin, by a presence pulse reported by the bus engine, or by a periodic attempt timer. A second periodic timer asks the bus engine for presence tests, and when the token no longer answers, the display is released. The pin polarity is configurable.

The block hands each attempt to an external sequencer with a one-cycle start pulse, and the sequencer returns a result code. Presence tests are requested from the bus engine with a one-cycle request, and the engine answers with a done strobe and a presence bit. The open-drain outputs are modelled as active-high pull-down enables. All timing derives from a prescaled tick input, so the delays can be scaled down for simulation. The quarter-second unit is `QTR_TICKS` ticks and the challenge delay is `CHD_TICKS` ticks.

Top module: `auth_trigger_ctrl`

## Requirements
- R1: When `cfg_chal_pol_i` is 1 the pin is active high and a rising edge starts an attempt. When it is 0 the pin is active low and a falling edge starts an attempt. Edges are only honoured once the power-up delay has elapsed. An edge towards the inactive level never starts an attempt.
- R2: If the synchronized pin is at its active level `CHD_TICKS` ticks after reset, exactly one attempt starts at that point. If it is inactive, no attempt starts.
- R3: With `cfg_async_en_i` = 1, a presence pulse seen while idle starts an attempt `CHD_TICKS` ticks later. With `cfg_async_en_i` = 0 the pulse is ignored.
- R4: `cfg_attempt_per_i` sets the periodic attempt interval: 00 none, 01 every 4 quarters, 10 every 32 quarters, 11 every 64 quarters.
- R5: `cfg_test_per_i` sets the periodic presence-test interval: 00 none, 01 every 1 quarter, 10 every 2 quarters, 11 every 4 quarters. A test that finds the token leaves the outputs and flags unchanged.
- R6: A presence test that finds no token releases both outputs and clears both flags on the next cycle.
- R7: Result code 01 (pass) drives `pass_pd_o` and sets `pass_flag_o`. The two pull-down outputs are never active together.
- R8: Result code 10 (fail) sets `fail_flag_o`. With `cfg_fail_pulse_i` = 0 the fail output is held active. With `cfg_fail_pulse_i` = 1 it alternates, active for one quarter and released for one quarter, starting with the active phase.
- R9: While an attempt is in progress the outputs keep their previous state. Both flags are cleared in the cycle the attempt starts.
- R10: Outside an attempt, the pin returning to its inactive level releases both outputs and clears both flags.
- R11: Result code 00 (token absent) releases both outputs and clears both flags. Reset leaves everything released and cleared.
- R12: `start_o` is a single-cycle pulse that is never asserted together with `ptest_req_o`. Triggers that arrive while an attempt is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick_i | input | 1 | Prescaled timing tick |
| chal_pin_i | input | 1 | Asynchronous challenge pin |
| cfg_chal_pol_i | input | 1 | Pin polarity, 1 = active high |
| cfg_async_en_i | input | 1 | Enable authentication on presence pulse |
| cfg_attempt_per_i | input | 2 | Periodic attempt interval code |
| cfg_test_per_i | input | 2 | Periodic presence-test interval code |
| cfg_fail_pulse_i | input | 1 | 1 = pulse fail output, 0 = hold |
| presence_seen_i | input | 1 | Asynchronous presence pulse reported by the bus engine |
| start_o | output | 1 | Start request to the sequencer |
| result_valid_i | input | 1 | Sequencer result strobe |
| result_code_i | input | 2 | 00 absent, 01 pass, 10 fail |
| ptest_req_o | output | 1 | Presence-test request to the bus engine |
| ptest_done_i | input | 1 | Presence-test completion strobe |
| ptest_present_i | input | 1 | Presence-test outcome, 1 = token answered |
| pass_pd_o | output | 1 | Pass output pull-down enable |
| fail_pd_o | output | 1 | Fail output pull-down enable |
| pass_flag_o | output | 1 | Pass flag |
| fail_flag_o | output | 1 | Fail flag |

## Verification
The power-up trigger is swept over both polarities and both pin levels, which separates a level-sampled start from a missing or inverted polarity decode. Each interval code of both timers is run and the spacing of the produced requests is measured, so a wrong interval code shows up as a wrong cycle count. The fail output is sampled over a fixed window in hold and pulse modes, and the count of active cycles separates the two modes and confirms the 50% duty. Presence pulses, retriggers during an attempt, inactive-pin returns and absent results are each followed by a check at the outputs. This shows which clearing and ignoring rules took effect.

// File: rtl/auth_trig_pkg.sv
package auth_trig_pkg;

    typedef enum logic [2:0] {
        TS_PWRUP,
        TS_IDLE,
        TS_DELAY,
        TS_BUSY,
        TS_PTEST
    } trig_state_e;

    typedef enum logic [1:0] {
        DISP_NONE,
        DISP_PASS,
        DISP_FAIL
    } disp_state_e;

    typedef enum logic [1:0] {
        RES_ABSENT = 2'd0,
        RES_PASS   = 2'd1,
        RES_FAIL   = 2'd2
    } res_code_e;

    localparam int PER_W = 7;

    typedef struct packed {
        logic act_edge;
        logic inact_edge;
        logic act_level;
    } chal_evt_t;

    function automatic logic [PER_W-1:0] attempt_quarters(input logic [1:0] code);
        case (code)
            2'b01:   return PER_W'(4);
            2'b10:   return PER_W'(32);
            2'b11:   return PER_W'(64);
            default: return '0;
        endcase
    endfunction

    function automatic logic [PER_W-1:0] test_quarters(input logic [1:0] code);
        case (code)
            2'b01:   return PER_W'(1);
            2'b10:   return PER_W'(2);
            2'b11:   return PER_W'(4);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/auth_qtr_prescale.sv
module auth_qtr_prescale #(
    parameter int QTR_TICKS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic qtick_o
);
    localparam int CW = (QTR_TICKS > 1) ? $clog2(QTR_TICKS) : 1;

    logic [CW-1:0] cnt;

    assign qtick_o = tick_i && (cnt == CW'(QTR_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (qtick_o) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/auth_period_timer.sv
module auth_period_timer
    import auth_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             qtick_i,
    input  logic [PER_W-1:0] period_i,
    output logic             fire_o
);
    logic [PER_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (period_i == '0) begin
                cnt <= '0;
            end else if (qtick_i) begin
                if (cnt >= period_i - 1'b1) begin
                    cnt    <= '0;
                    fire_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4 R5
    fire_after_qtick_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> $past(qtick_i));
endmodule

// File: rtl/auth_chal_sync.sv
module auth_chal_sync
    import auth_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  logic      pol_i,
    output chal_evt_t evt_o
);
    logic [SYNC_STAGES-1:0] sh;
    logic                   act, act_q;

    always_ff @(posedge clk) begin
        if (rst) sh[0] <= ~pol_i;
        else     sh[0] <= pin_i;
    end

    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sh[i] <= ~pol_i;
            else     sh[i] <= sh[i-1];
        end
    end

    assign act = pol_i ? sh[SYNC_STAGES-1] : ~sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= act;
    end

    assign evt_o.act_level  = act;
    assign evt_o.act_edge   = act & ~act_q;
    assign evt_o.inact_edge = ~act & act_q;
endmodule

// File: rtl/auth_status_disp.sv
module auth_status_disp
    import auth_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       qtick_i,
    input  logic       pulse_mode_i,
    input  logic       start_i,
    input  logic       res_valid_i,
    input  logic [1:0] res_code_i,
    input  logic       clr_i,
    output logic       pass_pd_o,
    output logic       fail_pd_o,
    output logic       pass_flag_o,
    output logic       fail_flag_o
);
    disp_state_e disp;
    logic        phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            disp        <= DISP_NONE;
            pass_flag_o <= 1'b0;
            fail_flag_o <= 1'b0;
            phase       <= 1'b1;
        end else begin
            if (disp == DISP_FAIL && qtick_i) phase <= ~phase;
            if (clr_i) begin
                disp        <= DISP_NONE;
                pass_flag_o <= 1'b0;
                fail_flag_o <= 1'b0;
            end else if (res_valid_i) begin
                if (res_code_i == RES_PASS) begin
                    disp        <= DISP_PASS;
                    pass_flag_o <= 1'b1;
                    fail_flag_o <= 1'b0;
                end else if (res_code_i == RES_ABSENT) begin
                    disp        <= DISP_NONE;
                    pass_flag_o <= 1'b0;
                    fail_flag_o <= 1'b0;
                end else begin
                    disp        <= DISP_FAIL;
                    pass_flag_o <= 1'b0;
                    fail_flag_o <= 1'b1;
                    phase       <= 1'b1;
                end
            end else if (start_i) begin
                pass_flag_o <= 1'b0;
                fail_flag_o <= 1'b0;
            end
        end
    end

    assign pass_pd_o = (disp == DISP_PASS);
    assign fail_pd_o = (disp == DISP_FAIL) && (!pulse_mode_i || phase);

    // R7
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(pass_pd_o && fail_pd_o));

    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !res_valid_i) |=> (!pass_flag_o && !fail_flag_o));

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_flag_o && !pulse_mode_i) |-> fail_pd_o);
endmodule

// File: rtl/auth_trigger_ctrl.sv
module auth_trigger_ctrl
    import auth_trig_pkg::*;
#(
    parameter int QTR_TICKS   = 250,
    parameter int CHD_TICKS   = 65,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       chal_pin_i,
    input  logic       cfg_chal_pol_i,
    input  logic       cfg_async_en_i,
    input  logic [1:0] cfg_attempt_per_i,
    input  logic [1:0] cfg_test_per_i,
    input  logic       cfg_fail_pulse_i,
    input  logic       presence_seen_i,
    output logic       start_o,
    input  logic       result_valid_i,
    input  logic [1:0] result_code_i,
    output logic       ptest_req_o,
    input  logic       ptest_done_i,
    input  logic       ptest_present_i,
    output logic       pass_pd_o,
    output logic       fail_pd_o,
    output logic       pass_flag_o,
    output logic       fail_flag_o
);
    localparam int DW = $clog2(CHD_TICKS + 1);

    trig_state_e   state, state_n;
    logic [DW-1:0] dly, dly_n;
    logic          start_n, ptreq_n, disp_clr;
    logic          qtick, att_fire, tst_fire;
    chal_evt_t     chal;

    auth_qtr_prescale #(.QTR_TICKS(QTR_TICKS)) u_pre (
        .clk(clk), .rst(rst), .tick_i(tick_i), .qtick_o(qtick)
    );

    auth_period_timer u_att_tmr (
        .clk(clk), .rst(rst), .qtick_i(qtick),
        .period_i(attempt_quarters(cfg_attempt_per_i)), .fire_o(att_fire)
    );

    auth_period_timer u_tst_tmr (
        .clk(clk), .rst(rst), .qtick_i(qtick),
        .period_i(test_quarters(cfg_test_per_i)), .fire_o(tst_fire)
    );

    auth_chal_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(chal_pin_i), .pol_i(cfg_chal_pol_i), .evt_o(chal)
    );

    always_comb begin
        state_n  = state;
        dly_n    = dly;
        start_n  = 1'b0;
        ptreq_n  = 1'b0;
        disp_clr = 1'b0;
        case (state)
            TS_PWRUP, TS_DELAY: begin
                if (tick_i) begin
                    if (dly == DW'(CHD_TICKS - 1)) begin
                        dly_n = '0;
                        if (state == TS_DELAY || chal.act_level) begin
                            start_n = 1'b1;
                            state_n = TS_BUSY;
                        end else begin
                            state_n = TS_IDLE;
                        end
                    end else begin
                        dly_n = dly + 1'b1;
                    end
                end
            end
            TS_IDLE: begin
                if (chal.act_edge || (att_fire && !(cfg_async_en_i && presence_seen_i))) begin
                    start_n = 1'b1;
                    state_n = TS_BUSY;
                end else if (cfg_async_en_i && presence_seen_i) begin
                    dly_n   = '0;
                    state_n = TS_DELAY;
                end else if (tst_fire) begin
                    ptreq_n = 1'b1;
                    state_n = TS_PTEST;
                end
            end
            TS_BUSY: begin
                if (result_valid_i) state_n = TS_IDLE;
            end
            TS_PTEST: begin
                if (ptest_done_i) begin
                    disp_clr = !ptest_present_i;
                    state_n  = TS_IDLE;
                end
            end
            default: state_n = TS_IDLE;
        endcase
        if (chal.inact_edge && state != TS_BUSY && state != TS_PWRUP) disp_clr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= TS_PWRUP;
            dly         <= '0;
            start_o     <= 1'b0;
            ptest_req_o <= 1'b0;
        end else begin
            state       <= state_n;
            dly         <= dly_n;
            start_o     <= start_n;
            ptest_req_o <= ptreq_n;
        end
    end

    auth_status_disp u_disp (
        .clk(clk), .rst(rst), .qtick_i(qtick), .pulse_mode_i(cfg_fail_pulse_i),
        .start_i(start_n), .res_valid_i(result_valid_i && state == TS_BUSY),
        .res_code_i(result_code_i), .clr_i(disp_clr),
        .pass_pd_o(pass_pd_o), .fail_pd_o(fail_pd_o),
        .pass_flag_o(pass_flag_o), .fail_flag_o(fail_flag_o)
    );

    // R12
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R12
    no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_o && ptest_req_o));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TS_BUSY && $past(state) == TS_BUSY) |-> ($stable(pass_pd_o) && $stable(pass_flag_o)));

    // R6
    absent_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TS_PTEST && ptest_done_i && !ptest_present_i)
            |=> (!pass_pd_o && !fail_pd_o && !pass_flag_o && !fail_flag_o));
endmodule

// File: tb/tb_auth_trigger_ctrl.sv
module tb_auth_trigger_ctrl;
    localparam int Q   = 4;
    localparam int CHD = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic chal_pin = 1'b1, pol = 1'b0, async_en = 1'b0, fpulse = 1'b0, presence = 1'b0;
    logic [1:0] att_per = 2'b00, tst_per = 2'b00;
    logic start_o, ptest_req_o, pass_pd, fail_pd, pass_flag, fail_flag;
    logic man_valid = 1'b0, auto_valid = 1'b0, auto_res = 1'b1;
    logic [1:0] man_code = 2'b00, auto_code = 2'b01;
    logic auto_present = 1'b1, pt_done = 1'b0, pt_present = 1'b0;
    logic res_valid;
    logic [1:0] res_code;

    assign res_valid = auto_res ? auto_valid : man_valid;
    assign res_code  = auto_res ? auto_code  : man_code;

    always #2.5 clk = ~clk;

    auth_trigger_ctrl #(.QTR_TICKS(Q), .CHD_TICKS(CHD)) dut (
        .clk(clk), .rst(rst), .tick_i(tick), .chal_pin_i(chal_pin),
        .cfg_chal_pol_i(pol), .cfg_async_en_i(async_en),
        .cfg_attempt_per_i(att_per), .cfg_test_per_i(tst_per),
        .cfg_fail_pulse_i(fpulse), .presence_seen_i(presence),
        .start_o(start_o), .result_valid_i(res_valid), .result_code_i(res_code),
        .ptest_req_o(ptest_req_o), .ptest_done_i(pt_done), .ptest_present_i(pt_present),
        .pass_pd_o(pass_pd), .fail_pd_o(fail_pd),
        .pass_flag_o(pass_flag), .fail_flag_o(fail_flag)
    );

    int cyc = 0, n_start = 0, n_pt = 0;
    int ts_prev = 0, ts_last = 0, tp_prev = 0, tp_last = 0;
    int checks = 0, fails = 0;

    always @(negedge clk) begin
        cyc++;
        if (start_o) begin n_start++; ts_prev = ts_last; ts_last = cyc; end
        if (ptest_req_o) begin n_pt++; tp_prev = tp_last; tp_last = cyc; end
        auto_valid = start_o;
        pt_done    = ptest_req_o;
        pt_present = auto_present;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic give_result(input logic [1:0] code);
        man_code  = code;
        man_valid = 1'b1;
        @(negedge clk);
        man_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_presence();
        presence = 1'b1;
        @(negedge clk);
        presence = 1'b0;
    endtask

    int s0, t0, d, ones, flg, exp_iv;

    initial begin
        // reset state, R11
        do_reset();
        chk(!pass_pd && !fail_pd && !pass_flag && !fail_flag && !start_o, "R11 reset",
            {pass_pd, fail_pd, pass_flag, fail_flag}, 0);

        // R2: power-up level sweep over polarity and level
        for (int p = 0; p < 2; p++) begin
            for (int lv = 0; lv < 2; lv++) begin
                pol = p[0]; chal_pin = lv[0]; auto_code = 2'b01;
                do_reset();
                s0 = n_start; t0 = cyc;
                repeat (CHD + 8) @(negedge clk);
                chk(n_start - s0 == (lv == p ? 1 : 0), "R2 powerup start count", n_start - s0, lv == p);
                if (lv == p) begin
                    d = ts_last - t0;
                    chk(d >= CHD - 1 && d <= CHD + 2, "R2 powerup delay", d, CHD);
                    chk(pass_pd && pass_flag && !fail_pd, "R7 pass shown", {pass_pd, pass_flag}, 3);
                end
            end
        end

        // R1 edge trigger, R8 hold, R10 clear on inactive return
        for (int p = 0; p < 2; p++) begin
            pol = p[0]; chal_pin = ~p[0]; fpulse = 1'b0; auto_code = 2'b10;
            do_reset();
            repeat (CHD + 6) @(negedge clk);
            s0 = n_start;
            chal_pin = p[0];
            repeat (6) @(negedge clk);
            chk(n_start - s0 == 1, "R1 active edge starts", n_start - s0, 1);
            ones = 0;
            for (int k = 0; k < 32; k++) begin ones += fail_pd; @(negedge clk); end
            chk(ones == 32, "R8 fail held", ones, 32);
            chk(fail_flag && !pass_pd, "R8 fail flag", fail_flag, 1);
            chal_pin = ~p[0];
            repeat (6) @(negedge clk);
            chk(!fail_pd && !fail_flag && !pass_pd, "R10 inactive clears", {fail_pd, fail_flag}, 0);
            chk(n_start - s0 == 1, "R1 inactive edge no start", n_start - s0, 1);
        end

        // R8 pulse mode (pol=1 from loop, pin low)
        fpulse = 1'b1;
        chal_pin = 1'b1;
        repeat (6) @(negedge clk);
        ones = 0; flg = 0;
        for (int k = 0; k < 32; k++) begin ones += fail_pd; flg += fail_flag; @(negedge clk); end
        chk(ones == 16, "R8 fail pulse duty", ones, 16);
        chk(flg == 32, "R8 fail flag steady", flg, 32);
        chal_pin = 1'b0;
        repeat (6) @(negedge clk);

        // R9, R12, R3, R11 with manual results
        auto_res = 1'b0; async_en = 1'b1; fpulse = 1'b0;
        s0 = n_start;
        chal_pin = 1'b1;
        repeat (5) @(negedge clk);
        give_result(2'b01);
        chk(pass_pd && pass_flag, "R7 manual pass", pass_pd, 1);
        t0 = cyc;
        pulse_presence();
        repeat (CHD + 4) @(negedge clk);
        d = ts_last - t0;
        chk(n_start - s0 == 2 && d >= CHD && d <= CHD + 3, "R3 async delay", d, CHD + 1);
        chk(pass_pd && !pass_flag, "R9 hold output clear flag", {pass_pd, pass_flag}, 2);
        pulse_presence();
        repeat (CHD + 6) @(negedge clk);
        chk(pass_pd && n_start - s0 == 2, "R12 busy ignores trigger", n_start - s0, 2);
        give_result(2'b10);
        repeat (CHD + 6) @(negedge clk);
        chk(fail_pd && n_start - s0 == 2, "R12 dropped trigger stays dropped", n_start - s0, 2);
        pulse_presence();
        repeat (CHD + 4) @(negedge clk);
        give_result(2'b00);
        chk(!pass_pd && !fail_pd && !pass_flag && !fail_flag, "R11 absent clears",
            {pass_pd, fail_pd, pass_flag, fail_flag}, 0);
        async_en = 1'b0; s0 = n_start;
        pulse_presence();
        repeat (CHD + 6) @(negedge clk);
        chk(n_start == s0, "R3 async disabled ignored", n_start - s0, 0);

        // R4 periodic attempt sweep
        auto_res = 1'b1; auto_code = 2'b01; chal_pin = 1'b0; pol = 1'b1;
        for (int c = 0; c < 4; c++) begin
            att_per = c[1:0];
            do_reset();
            s0 = n_start;
            exp_iv = (c == 1) ? 4 * Q : (c == 2) ? 32 * Q : (c == 3) ? 64 * Q : 0;
            if (c == 0) begin
                repeat (300) @(negedge clk);
                chk(n_start == s0, "R4 code 00 no attempts", n_start - s0, 0);
            end else begin
                for (int k = 0; k < 4 * exp_iv + 50 && n_start - s0 < 3; k++) @(negedge clk);
                chk(ts_last - ts_prev == exp_iv, "R4 attempt interval", ts_last - ts_prev, exp_iv);
            end
        end
        att_per = 2'b00;

        // R5 presence test sweep, then R6 removal
        for (int c = 0; c < 4; c++) begin
            tst_per = 2'b00; auto_present = 1'b1; chal_pin = 1'b0;
            do_reset();
            repeat (CHD + 6) @(negedge clk);
            chal_pin = 1'b1;
            repeat (6) @(negedge clk);
            tst_per = c[1:0];
            s0 = n_pt;
            exp_iv = (c == 0) ? 0 : (Q << (c - 1));
            if (c == 0) begin
                repeat (100) @(negedge clk);
                chk(n_pt == s0, "R5 code 00 no tests", n_pt - s0, 0);
            end else begin
                for (int k = 0; k < 6 * exp_iv + 50 && n_pt - s0 < 3; k++) @(negedge clk);
                chk(tp_last - tp_prev == exp_iv, "R5 test interval", tp_last - tp_prev, exp_iv);
                chk(pass_pd && pass_flag, "R5 present keeps display", {pass_pd, pass_flag}, 3);
                auto_present = 1'b0;
                repeat (exp_iv + 4) @(negedge clk);
                chk(!pass_pd && !pass_flag, "R6 removal clears", {pass_pd, pass_flag}, 0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule